// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous system bus and an external 64K x 8 asynchronous static RAM. A single-cycle request on the user side starts the access. The block then produces the chip-enable, output-enable and write-enable strobe sequence the RAM needs, with the timing set in clock cycles. It returns a one-cycle ready pulse and, for reads, a registered data byte. The RAM is selected only when its active-low enable is low and its active-high enable is high. The controller keeps the RAM deselected, in its low-power standby, whenever no access is under way. The shared data bus is split at the block edge into an output value, an output-enable and an input value, so a pad-level tristate can be built outside.

The access length comes from the parameter `WAIT_CYCLES`. It should be the RAM access time divided by the clock period, rounded up, and any value below 1 is treated as 1. The same count sets the width of the read strobe and the width of the write strobe.

The state machine has six states:
- `ST_IDLE`: standby. Requests are accepted only in this state.
- `ST_READ_WAIT`: read strobes active for the wait count.
- `ST_WRITE_SETUP`: one cycle with the chip enabled and data driven while write enable is still high.
- `ST_WRITE_PULSE`: write enable low for the wait count.
- `ST_WRITE_HOLD`: one cycle after write enable rises, with address, enables and data held.
- `ST_TURNAROUND`: one fully quiet cycle after every read.

The transitions are:
- IDLE to READ_WAIT on a request with `we_i`=0.
- IDLE to WRITE_SETUP on a request with `we_i`=1.
- READ_WAIT to TURNAROUND when the wait count ends.
- WRITE_SETUP to WRITE_PULSE.
- WRITE_PULSE to WRITE_HOLD when the wait count ends.
- WRITE_HOLD to IDLE.
- TURNAROUND to IDLE.

A synchronous reset forces IDLE.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, the outputs are `mem_ce1_n_o`=1, `mem_ce2_o`=0, `mem_oe_n_o`=1, `mem_we_n_o`=1, `mem_dq_oe_o`=0 and `ready_o`=0.
- R2: Whenever neither the read strobe (`mem_oe_n_o`=0) nor the data drivers (`mem_dq_oe_o`=1) are active, the RAM is deselected: `mem_ce1_n_o`=1 and `mem_ce2_o`=0.
- R3: A request with `we_i`=0 accepted in idle holds `mem_oe_n_o` low for exactly `WAIT_CYCLES` cycles, starting in the next cycle. During that window both enables are active, `mem_we_n_o`=1 and `mem_dq_oe_o`=0.
- R4: For a read, `rdata_o` takes the value on `mem_dq_i` in the last cycle of the read strobe. That value is valid when `ready_o` pulses in the following cycle and is held until the next read completes.
- R5: A write first drives a setup cycle in which both enables are active, data is driven and `mem_we_n_o`=1. Then `mem_we_n_o` goes low for exactly `WAIT_CYCLES` cycles. `ready_o` pulses in the cycle after the hold cycle.
- R6: In the cycle in which `mem_we_n_o` rises, both enables stay active, `mem_dq_oe_o`=1, and `mem_addr_o` and `mem_dq_o` are unchanged, equal to the request's address and data.
- R7: Every read is followed by a cycle with all strobes inactive and the drivers off, and `ready_o` is high in that cycle. `mem_dq_oe_o` rises only when `mem_oe_n_o` was high in the previous cycle.
- R8: A request raised while an access is in progress is ignored. It causes no strobe, no extra `ready_o` pulse and no change to RAM contents.
- R9: `ready_o` is never high for two consecutive cycles.
- R10: `mem_dq_oe_o` and a low `mem_oe_n_o` never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | One-cycle access request, taken only when idle |
| we_i | input | 1 | 1 = write, 0 = read, sampled with the request |
| addr_i | input | 16 | Word address, sampled with the request |
| wdata_i | input | 8 | Write byte, sampled with the request |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte from the last completed read |
| mem_addr_o | output | 16 | RAM address |
| mem_ce1_n_o | output | 1 | RAM enable, active low |
| mem_ce2_o | output | 1 | RAM enable, active high |
| mem_oe_n_o | output | 1 | RAM output enable, active low |
| mem_we_n_o | output | 1 | RAM write enable, active low |
| mem_dq_o | output | 8 | Value driven onto the RAM data bus |
| mem_dq_oe_o | output | 1 | Drive enable for the RAM data bus |
| mem_dq_i | input | 8 | Value read from the RAM data bus |

## Verification
The embedded assertions check the strobe relationships on every cycle:
- standby whenever the block is idle;
- no drive while output enable is low;
- one setup cycle before write enable falls and held address and data when it rises;
- strobe widths matching the wait count, measured by counters;
- single-cycle ready pulses.

Only the bench's scenarios can show the data behaviour. This covers whether the right byte lands at the right address, whether read data matches what an earlier write stored, and whether a request raised mid-access leaves memory and the handshake untouched. The bench shows these through a memory model and a scoreboard of expected completions.

// File: rtl/asram_pkg.sv
package asram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_WAIT,
        ST_WRITE_SETUP,
        ST_WRITE_PULSE,
        ST_WRITE_HOLD,
        ST_TURNAROUND
    } asram_state_e;
endpackage

// File: rtl/asram_wait_timer.sv
// Down-counter that sets the length of each strobe window in clock cycles.
module asram_wait_timer #(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic done_o
);
    localparam int WAIT_EFF = (WAIT_CYCLES < 1) ? 1 : WAIT_CYCLES;
    localparam int CNT_W    = (WAIT_EFF < 2) ? 1 : $clog2(WAIT_EFF);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_EFF - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/asram_datapath.sv
// Registers for the request address and write byte (held through the whole
// access) and for the returned read byte.
module asram_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [DATA_W-1:0] wdata_q_o,
    output logic [DATA_W-1:0] rdata_q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q_o  <= '0;
            wdata_q_o <= '0;
        end else if (accept_i) begin
            addr_q_o  <= addr_i;
            wdata_q_o <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q_o <= '0;
        end else if (capture_i) begin
            rdata_q_o <= mem_dq_i;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int WAIT_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce1_n_o,
    output logic              mem_ce2_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int WAIT_EFF = (WAIT_CYCLES < 1) ? 1 : WAIT_CYCLES;

    asram_state_e state_q, state_d;
    logic accept, timer_load, timer_done, capture, ready_q;

    assign accept     = (state_q == ST_IDLE) && req_i;
    assign timer_load = (accept && !we_i) || (state_q == ST_WRITE_SETUP);
    assign capture    = (state_q == ST_READ_WAIT) && timer_done;

    asram_wait_timer #(.WAIT_CYCLES(WAIT_EFF)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (timer_load),
        .done_o (timer_done)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
        .clk       (clk),
        .rst       (rst),
        .accept_i  (accept),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .capture_i (capture),
        .mem_dq_i  (mem_dq_i),
        .addr_q_o  (mem_addr_o),
        .wdata_q_o (mem_dq_o),
        .rdata_q_o (rdata_o)
    );

    // State register and ready pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ready_q <= capture || (state_q == ST_WRITE_HOLD);
        end
    end

    assign ready_o = ready_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (req_i) state_d = we_i ? ST_WRITE_SETUP : ST_READ_WAIT;
            ST_READ_WAIT:   if (timer_done) state_d = ST_TURNAROUND;
            ST_WRITE_SETUP: state_d = ST_WRITE_PULSE;
            ST_WRITE_PULSE: if (timer_done) state_d = ST_WRITE_HOLD;
            ST_WRITE_HOLD:  state_d = ST_IDLE;
            ST_TURNAROUND:  state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // Strobe decode
    always_comb begin
        mem_ce1_n_o = 1'b1;
        mem_ce2_o   = 1'b0;
        mem_oe_n_o  = 1'b1;
        mem_we_n_o  = 1'b1;
        mem_dq_oe_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_TURNAROUND: ;
            ST_READ_WAIT: begin
                mem_ce1_n_o = 1'b0;
                mem_ce2_o   = 1'b1;
                mem_oe_n_o  = 1'b0;
            end
            ST_WRITE_SETUP, ST_WRITE_HOLD: begin
                mem_ce1_n_o = 1'b0;
                mem_ce2_o   = 1'b1;
                mem_dq_oe_o = 1'b1;
            end
            ST_WRITE_PULSE: begin
                mem_ce1_n_o = 1'b0;
                mem_ce2_o   = 1'b1;
                mem_we_n_o  = 1'b0;
                mem_dq_oe_o = 1'b1;
            end
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    logic [15:0] we_low_cnt, oe_low_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt <= '0;
            oe_low_cnt <= '0;
        end else begin
            we_low_cnt <= mem_we_n_o ? 16'd0 : we_low_cnt + 16'd1;
            oe_low_cnt <= mem_oe_n_o ? 16'd0 : oe_low_cnt + 16'd1;
        end
    end

    assert_reset_standby_R1: assert property (@(posedge clk)
        rst |=> (mem_ce1_n_o && !mem_ce2_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o && !ready_o));

    assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_oe_n_o && !mem_dq_oe_o) |-> (mem_ce1_n_o && !mem_ce2_o));

    assert_read_width_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n_o) |-> (oe_low_cnt == 16'(WAIT_EFF)));

    assert_write_setup_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n_o) |-> $past(!mem_ce1_n_o && mem_ce2_o && mem_dq_oe_o && mem_we_n_o));

    assert_write_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n_o) |-> (we_low_cnt == 16'(WAIT_EFF)));

    assert_write_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n_o) |-> (!mem_ce1_n_o && mem_ce2_o && mem_dq_oe_o
                               && $stable(mem_addr_o) && $stable(mem_dq_o)));

    assert_bus_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe_o) |-> $past(mem_oe_n_o));

    assert_ready_single_R9: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> !ready_o);

    assert_no_contention_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe_o && !mem_oe_n_o));
endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WAITC      = 3;

    typedef struct packed {
        logic        is_wr;
        logic [15:0] addr;
        logic [7:0]  data;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we  = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready;
    logic [7:0]  rdata;
    logic [15:0] mem_addr;
    logic        ce1_n, ce2, oe_n, we_n, dq_oe;
    logic [7:0]  dq_out, dq_in;

    int total = 0;
    int fails = 0;
    sb_item_t sbq[$];
    logic [7:0] ram [256];
    logic [7:0] shadow [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_ctrl #(.ADDR_W(16), .DATA_W(8), .WAIT_CYCLES(WAITC)) uut (
        .clk(clk), .rst(rst), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .ready_o(ready), .rdata_o(rdata), .mem_addr_o(mem_addr),
        .mem_ce1_n_o(ce1_n), .mem_ce2_o(ce2), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
        .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in)
    );

    // RAM model: byte array indexed by the low address byte
    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i]    = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
    end
    always @(posedge we_n) begin
        if (!rst && !ce1_n && ce2) ram[mem_addr[7:0]] = dq_out;
    end
    assign dq_in = (!ce1_n && ce2 && !oe_n && we_n) ? ram[mem_addr[7:0]] : 8'hEE;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // Driver: issue a request, push the expected completion, wait for ready
    task automatic access(input logic is_wr, input logic [15:0] a, input logic [7:0] d);
        sb_item_t it;
        it.is_wr = is_wr;
        it.addr  = a;
        it.data  = is_wr ? d : shadow[a[7:0]];
        if (is_wr) shadow[a[7:0]] = d;
        sbq.push_back(it);
        @(negedge clk);
        req = 1'b1; we = is_wr; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        while (!ready) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    logic        p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0, p_ready = 1'b0;
    logic        p_ce_act = 1'b0;
    logic [15:0] p_addr = '0;
    logic [7:0]  p_dq = '0;
    int          we_run = 0, oe_run = 0;
    logic [15:0] cap_addr = '0;
    logic [7:0]  cap_data = '0;

    always @(negedge clk) begin
        if (!rst) begin
            automatic logic ce_act = !ce1_n && ce2;
            if (p_we_n && !we_n)
                chk(p_ce_act && p_dq_oe, "R5 setup before write strobe", {p_ce_act, p_dq_oe}, 2'b11);
            if (!p_oe_n && oe_n)
                chk(oe_run == WAITC, "R3 read strobe width", oe_run, WAITC);
            if (p_oe_n && !oe_n)
                chk(ce_act && we_n && !dq_oe, "R3/R10 read strobe qualifiers", {ce_act, we_n, dq_oe}, 3'b110);
            if (!p_we_n && we_n) begin
                chk(we_run == WAITC, "R5 write strobe width", we_run, WAITC);
                chk(ce_act && dq_oe && (mem_addr == p_addr) && (dq_out == p_dq),
                    "R6 hold at write strobe rise", {ce_act, dq_oe, mem_addr == p_addr, dq_out == p_dq}, 4'hF);
                cap_addr = mem_addr;
                cap_data = dq_out;
            end
            if (!p_dq_oe && dq_oe)
                chk(p_oe_n, "R7 output disabled before drive", p_oe_n, 1'b1);
            if (ready) begin
                chk(!p_ready, "R9 ready single cycle", p_ready, 1'b0);
                if (sbq.size() == 0) begin
                    chk(1'b0, "R8 unexpected ready", 1, 0);
                end else begin
                    automatic sb_item_t it = sbq.pop_front();
                    if (it.is_wr) begin
                        chk(cap_addr == it.addr, "R6 write address", cap_addr, it.addr);
                        chk(cap_data == it.data, "R6 write data", cap_data, it.data);
                        chk(ce1_n && !ce2 && oe_n && we_n && !dq_oe, "R2 standby after write",
                            {ce1_n, ce2, oe_n, we_n, dq_oe}, 5'b10110);
                    end else begin
                        chk(rdata == it.data, "R4 read data", rdata, it.data);
                        chk(ce1_n && !ce2 && oe_n && we_n && !dq_oe, "R7 quiet turnaround cycle",
                            {ce1_n, ce2, oe_n, we_n, dq_oe}, 5'b10110);
                    end
                end
            end
            we_run = we_n ? 0 : we_run + 1;
            oe_run = oe_n ? 0 : oe_run + 1;
            p_ce_act = ce_act;
        end
        p_we_n = we_n; p_oe_n = oe_n; p_dq_oe = dq_oe; p_ready = ready;
        p_addr = mem_addr; p_dq = dq_out;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        chk(ce1_n && !ce2 && oe_n && we_n && !dq_oe && !ready, "R1 outputs in reset",
            {ce1_n, ce2, oe_n, we_n, dq_oe, ready}, 6'b101100);
        rst = 1'b0;
        @(negedge clk);
        chk(ce1_n && !ce2 && oe_n && we_n && !dq_oe && !ready, "R1 outputs after reset",
            {ce1_n, ce2, oe_n, we_n, dq_oe, ready}, 6'b101100);
        repeat (2) @(negedge clk);
        chk(ce1_n && !ce2, "R2 idle standby", {ce1_n, ce2}, 2'b10);

        access(1'b0, 16'h1234, 8'h00);          // unwritten location (R3, R4)
        access(1'b1, 16'h00A5, 8'h5A);          // R5, R6
        access(1'b0, 16'h00A5, 8'h00);          // read-back
        access(1'b1, 16'hFFFF, 8'hFF);          // top address, all-ones data
        access(1'b1, 16'h0000, 8'h00);          // bottom address, zero data
        access(1'b0, 16'hFFFF, 8'h00);
        access(1'b0, 16'h0000, 8'h00);          // read-read back to back
        access(1'b1, 16'h3C10, 8'hC3);          // read then write: R7
        access(1'b0, 16'h3C10, 8'h00);          // write then read

        // R8: request raised while a read is in flight is ignored
        sbq.push_back('{is_wr: 1'b0, addr: 16'h2042, data: shadow[8'h42]});
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 16'h2042;
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 16'h0077; wdata = 8'hFF;
        @(negedge clk);
        req = 1'b0;
        while (!ready) @(negedge clk);
        held = rdata;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(we_n && !ready, "R8 ignored request causes no access", {we_n, ready}, 2'b10);
        end
        access(1'b0, 16'h0077, 8'h00);          // location unchanged (R8)

        // R4: read data held across a following write
        access(1'b0, 16'h0042, 8'h00);
        held = rdata;
        access(1'b1, 16'h0099, 8'h11);
        chk(rdata == held, "R4 read data held across write", rdata, held);

        for (int j = 0; j < 8; j++) begin
            access(1'b1, 16'(16'h5100 + j * 16'h0103), 8'(j * 37 + 1));
            access(1'b0, 16'(16'h5100 + j * 16'h0103), 8'h00);
        end

        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R9 all completions seen", sbq.size(), 0);
        report();
        $finish;
    end
endmodule